// File: doc/BRIEF.md
# Transmit FIFO with Low-Water Flag

This block is the sixteen-byte transmit queue of a serial port. A processor or a DMA engine pushes bytes in through one write port. The bit shifter behind it pops them in arrival order, and the head byte is always visible on the read data output. The block tracks how many bytes are held and shows that count in the upper byte of a 16-bit status word.

A low-water flag tells the writer when more bytes may be sent. The flag is raised whenever a pop leaves the occupancy at or under a threshold chosen by a two-bit select. Once raised, it stays raised. Software can drop it only by reading it as 1 first and then writing 0, and only if the FIFO then holds more than the threshold. A DMA push that lifts the occupancy over the threshold drops it without any handshake. A standby input holds the flag high.

Top module: `txfifo_lowater`

## Requirements
- R1: Popped bytes leave in the order they were pushed. `pop_data` shows the oldest held byte whenever the occupancy is non-zero. A pop while the FIFO is empty is ignored.
- R2: A push is dropped when the occupancy is 16 at the start of the cycle, even if a pop happens in the same cycle. The occupancy never exceeds 16.
- R3: An accepted push together with an accepted pop in one cycle leaves the occupancy unchanged.
- R4: `trig_sel` values 0, 1, 2 and 3 select thresholds of 8, 4, 2 and 0 bytes. An accepted pop that leaves the occupancy at or below the threshold sets `lowater` on the next cycle.
- R5: After reset, `lowater` is 1 and the occupancy is 0. While `standby` is 1, `lowater` is forced to 1 from the next cycle, and this overrides every clearing condition.
- R6: A status write with `stat_wflag`=0 clears `lowater` only if a qualifying read is pending and the occupancy after that cycle exceeds the threshold.
- R7: A status read (`stat_rd`) while `lowater` is 1 arms the qualifier. Any status write disarms it. A write of 0 with no qualifier armed leaves `lowater` unchanged.
- R8: An accepted push with `wr_dma`=1 that leaves the occupancy above the threshold clears `lowater` on the next cycle, unless a pop in the same cycle sets it (R4).
- R9: `stat_count[15:8]` equals the occupancy, and `stat_count[7:0]` is 0.
- R10: `lowater` falls only in the cycle after a status write or a DMA push. A push by the processor never clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Holds the low-water flag at 1 |
| trig_sel | input | 2 | Threshold select (0:8, 1:4, 2:2, 3:0 bytes) |
| wr_en | input | 1 | Push request |
| wr_dma | input | 1 | Marks the push as coming from the DMA engine |
| wr_data | input | 8 | Byte to push |
| pop | input | 1 | Pop request from the shifter side |
| pop_data | output | 8 | Oldest held byte |
| stat_rd | input | 1 | Status read strobe, samples the flag for the qualifier |
| stat_wr | input | 1 | Status write strobe |
| stat_wflag | input | 1 | Flag value carried by the status write |
| lowater | output | 1 | Low-water flag |
| stat_count | output | 16 | Occupancy in the upper byte, zero in the lower byte |

## Verification
Directed sequences first overfill the FIFO with processor pushes. This separates a dropped push from a wrapped pointer, and shows that processor pushes leave the flag high. A zero write is then tried with and without a preceding read, which tells a real handshake apart from a flag that any write clears. Draining across each threshold and refilling by DMA separates the setting path from the DMA clearing path. Random mixes then overlap push, pop, status traffic, standby and threshold changes in one cycle. These overlaps test the priority order between standby, pop-set, DMA clear and software clear, as well as the unchanged count for a simultaneous push and pop.

// File: rtl/txfifo_lowater.sv
module txfifo_lowater #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic [1:0]       trig_sel,
  input  logic             wr_en,
  input  logic             wr_dma,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  input  logic             stat_rd,
  input  logic             stat_wr,
  input  logic             stat_wflag,
  output logic             lowater,
  output logic [15:0]      stat_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    count, nxt, thr;
  logic             qual, flag_n, qual_n;

  wire push_ok = wr_en && (count != CW'(DEPTH));
  wire pop_ok  = pop && (count != '0);

  always_comb
    case (trig_sel)
      2'd0:    thr = CW'(DEPTH / 2);
      2'd1:    thr = CW'(DEPTH / 4);
      2'd2:    thr = CW'(DEPTH / 8);
      default: thr = '0;
    endcase

  assign nxt = count + CW'(push_ok) - CW'(pop_ok);

  always_comb begin
    flag_n = lowater;
    if (standby)                                      flag_n = 1'b1;
    else if (pop_ok && nxt <= thr)                    flag_n = 1'b1;
    else if (push_ok && wr_dma && nxt > thr)          flag_n = 1'b0;
    else if (stat_wr && !stat_wflag && qual && nxt > thr) flag_n = 1'b0;
  end

  assign qual_n = stat_wr ? 1'b0 : ((stat_rd && lowater) ? 1'b1 : qual);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      lowater <= 1'b1;
      qual    <= 1'b0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      count   <= nxt;
      lowater <= flag_n;
      qual    <= qual_n;
    end

  assign pop_data   = mem[rp];
  assign stat_count = {{(8 - CW){1'b0}}, count, 8'h00};
endmodule

// File: rtl/txfifo_lowater_chk.sv
module txfifo_lowater_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby,
  input logic [1:0]    trig_sel,
  input logic          wr_en,
  input logic          wr_dma,
  input logic          pop,
  input logic          stat_wr,
  input logic          lowater,
  input logic [CW-1:0] count
);
  int thr;
  always_comb
    case (trig_sel)
      2'd0:    thr = DEPTH / 2;
      2'd1:    thr = DEPTH / 4;
      2'd2:    thr = DEPTH / 8;
      default: thr = 0;
    endcase

  wire full  = (int'(count) == DEPTH);
  wire empty = (count == '0);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  a_r3_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pop && !empty && !full) |=> $stable(count));
  a_r4_pop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !(wr_en && !full) && (int'(count) - 1 <= thr)) |=> lowater);
  a_r5_standby_forces: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> lowater);
  a_r10_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lowater) |-> $past(stat_wr || (wr_en && wr_dma)));
endmodule

bind txfifo_lowater txfifo_lowater_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .trig_sel(trig_sel),
  .wr_en(wr_en), .wr_dma(wr_dma), .pop(pop), .stat_wr(stat_wr),
  .lowater(lowater), .count(count)
);

// File: tb/txfifo_lowater_bench.sv
`timescale 1ns/1ps
module txfifo_lowater_bench;
  logic clk = 0, rst_n = 0;
  logic standby = 0, wr_en = 0, wr_dma = 0, pop = 0;
  logic stat_rd = 0, stat_wr = 0, stat_wflag = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] wr_data = 0, pop_data;
  logic lowater;
  logic [15:0] stat_count;

  txfifo_lowater u_txfifo_lowater (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  byte unsigned mq[$];
  bit mf = 1, mqual = 0;
  string why_f, why_c;

  function automatic int trig_of(input logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 4; 2'd2: return 2; default: return 0; endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit push_ok, pop_ok;
    int nx, thr;
    push_ok = wr_en && mq.size() < 16;
    pop_ok  = pop && mq.size() > 0;
    nx  = mq.size() + int'(push_ok) - int'(pop_ok);
    thr = trig_of(trig_sel);
    why_c = (wr_en && mq.size() == 16) ? "R2 full drop" :
            (push_ok && pop_ok) ? "R3 push+pop count" : "R9 count";
    why_f = (stat_wr && !stat_wflag) ? "R7 write without qualifier" : "R10 flag hold";
    if (standby) begin mf = 1; why_f = "R5 standby"; end
    else if (pop_ok && nx <= thr) begin mf = 1; why_f = "R4 pop sets"; end
    else if (push_ok && wr_dma && nx > thr) begin mf = 0; why_f = "R8 dma clear"; end
    else if (stat_wr && !stat_wflag && mqual && nx > thr) begin mf = 0; why_f = "R6 sw clear"; end
    mqual = stat_wr ? 0 : ((stat_rd && mf_prev_hold()) ? 1 : mqual);
    if (pop_ok) void'(mq.pop_front());
    if (push_ok) mq.push_back(wr_data);
  endtask

  bit mf_old;
  function automatic bit mf_prev_hold();
    return mf_old;
  endfunction

  task automatic cyc(input bit w, input bit d, input bit p, input bit sr, input bit sw,
                     input bit wf, input bit sb, input logic [1:0] ts);
    wr_en = w; wr_dma = d; pop = p; stat_rd = sr; stat_wr = sw; stat_wflag = wf;
    standby = sb; trig_sel = ts; wr_data = 8'($urandom);
    #0.1;
    if (mq.size() > 0) chk("R1 head byte", pop_data, mq[0]);
    mf_old = mf;
    model_step();
    @(negedge clk);
    chk(why_c, stat_count[15:8], mq.size());
    chk("R9 low byte", stat_count[7:0], 0);
    chk(why_f, lowater, mf);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R5 reset flag", lowater, 1);
    chk("R5 reset count", stat_count, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 17; i++) cyc(1, 0, 0, 0, 0, 0, 0, 2'd0);
    cyc(0, 0, 1, 0, 0, 0, 0, 2'd0);
    cyc(1, 0, 0, 0, 0, 0, 0, 2'd0);
    cyc(1, 0, 1, 0, 0, 0, 0, 2'd0);
    cyc(0, 0, 0, 0, 1, 0, 0, 2'd0);
    cyc(0, 0, 0, 1, 0, 0, 0, 2'd0);
    cyc(0, 0, 0, 0, 1, 0, 0, 2'd0);
    cyc(0, 0, 0, 0, 1, 0, 0, 2'd0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 0, 0, 0, 2'd0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 0, 0, 0, 2'd1);
    cyc(0, 0, 1, 0, 0, 0, 0, 2'd1);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 0, 0, 2'd2);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd2);
    cyc(1, 1, 0, 0, 0, 0, 1, 2'd2);
    cyc(1, 1, 0, 0, 0, 0, 0, 2'd3);
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] ts;
      ts = ($urandom_range(0, 19) == 0) ? 2'($urandom) : trig_sel;
      cyc($urandom_range(0, 99) < 50, $urandom_range(0, 1), $urandom_range(0, 99) < 45,
          $urandom_range(0, 99) < 15, $urandom_range(0, 99) < 10, $urandom_range(0, 1),
          $urandom_range(0, 49) == 0, ts);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule